// File: doc/BRIEF.md
# Clock Multiplier Power-Up Sequencer

This block drives the three control lines of an on-chip clock multiplier: a bypass-release line, an active-low reset and an output gate. It changes them in a safe order. An enable request releases the bypass first. After a fixed settling gap it takes the multiplier out of reset. It then polls the lock indicator once per microsecond and opens the output gate when lock is seen. If lock never appears within a bounded number of polls, the sequence ends and a timeout flag is raised. A disable request closes the output gate, waits a short gap, and then drops reset and bypass-release together.

When a strap selects vote mode, a separate hardware state machine owns the multiplier. In that mode an enable request only raises a vote line and waits for that machine's active flag, polled on the same bounded schedule. A disable request only withdraws the vote. All waits are counted in microsecond ticks. An internal prescaler makes these ticks from the system clock, and it restarts at the start of every wait, so each gap is an exact number of clock cycles.

Top module: `clkmul_sequencer`

## Requirements
- R1: After an accepted enable request outside vote mode, `bypassRel` rises on the accepting clock edge. `pllRstN` rises exactly BYP_GAP_US×TICK_DIV cycles later, and neither line rises without the other's precondition (`outEn` implies `pllRstN`, and `pllRstN` implies `bypassRel`).
- R2: After reset release, `lockDet` is sampled once every TICK_DIV cycles. `outEn` rises, and `done` pulses, on the first such sample where lock is high, k×TICK_DIV cycles after reset release (k at most POLL_MAX).
- R3: If lock is not seen on any of POLL_MAX samples, the sequence ends POLL_MAX×TICK_DIV cycles after reset release. `timeoutErr` is set, `done` pulses, `outEn` stays 0 and bypass and reset stay released. The next accepted request clears `timeoutErr`.
- R4: An enable request that finds `bypassRel`, `pllRstN` and `outEn` all at 1 pulses `done` in the cycle after acceptance and changes no control line.
- R5: A disable request outside vote mode clears `outEn` on the accepting edge. `pllRstN` and `bypassRel` fall together DIS_GAP_US×TICK_DIV cycles later, in the cycle in which `done` pulses.
- R6: In vote mode an enable request raises `voteOut` on the accepting edge and leaves all three control lines unchanged. It then polls `activeFlag` on the R2 schedule, ending with `done` on success, or with `timeoutErr` after POLL_MAX samples.
- R7: In vote mode a disable request drops `voteOut` on the accepting edge, with `done` in the following cycle and no control line touched.
- R8: Requests that arrive while `busy` is 1 are ignored. If enable and disable are requested in the same idle cycle, the enable is taken.
- R9: After reset, all outputs are 0. `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enReq | input | 1 | Enable request pulse |
| disReq | input | 1 | Disable request pulse |
| voteStrap | input | 1 | Selects vote mode when 1 |
| lockDet | input | 1 | Lock indicator from the multiplier |
| activeFlag | input | 1 | Active indicator from the voting state machine |
| bypassRel | output | 1 | Bypass release control line |
| pllRstN | output | 1 | Active-low multiplier reset (1 = released) |
| outEn | output | 1 | Output gate control line |
| voteOut | output | 1 | Vote line to the voting state machine |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| timeoutErr | output | 1 | Lock or active flag not seen within the poll limit |

## Verification
The bench builds the block with TICK_DIV=4, BYP_GAP_US=5, DIS_GAP_US=1 and POLL_MAX=12. With these values one microsecond is four cycles, and a full poll window takes only 48 cycles. Random lock and active delays can therefore fall on either side of the poll limit, reaching the first-sample lock, the last-sample lock and the timeout within a few hundred cycles per sequence. A tick of more than one cycle also lets the bench tell a wait counted in ticks from one counted in cycles.

// File: rtl/clkmul_seq_pkg.sv
package clkmul_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EN_GAP,
    S_EN_POLL,
    S_VOTE_POLL,
    S_DIS_GAP,
    S_FIN
  } seqState_t;

  // Strobes from control to datapath, each valid for one cycle.
  typedef struct packed {
    logic setByp;
    logic setRst;
    logic setOut;
    logic clrOut;
    logic clrRstByp;
    logic setVote;
    logic clrVote;
    logic clrTimer;
    logic setErr;
    logic clrErr;
  } seqStrobe_t;

endpackage

// File: rtl/clkmul_seq_dp.sv
module clkmul_seq_dp
  import clkmul_seq_pkg::*;
#(
  parameter int TICK_DIV = 100,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  output logic             tick,
  output logic [CNT_W-1:0] usCnt,
  output logic             bypassRel,
  output logic             pllRstN,
  output logic             outEn,
  output logic             voteOut,
  output logic             timeoutErr
);

  // Microsecond tick: the prescaler restarts with every wait.
  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strb.clrTimer) preCnt <= '0;
        else if (preCnt == PRE_W'(TICK_DIV - 1)) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // Tick counter, shared by the gaps and the poll budget.
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrTimer) usCnt <= '0;
    else if (tick && (usCnt != '1)) usCnt <= usCnt + 1'b1;
  end

  // Control lines.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypassRel  <= 1'b0;
      pllRstN    <= 1'b0;
      outEn      <= 1'b0;
      voteOut    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (strb.setByp) bypassRel <= 1'b1;
      if (strb.setRst) pllRstN <= 1'b1;
      if (strb.setOut) outEn <= 1'b1;
      if (strb.clrOut) outEn <= 1'b0;
      if (strb.clrRstByp) begin
        pllRstN   <= 1'b0;
        bypassRel <= 1'b0;
      end
      if (strb.setVote) voteOut <= 1'b1;
      if (strb.clrVote) voteOut <= 1'b0;
      if (strb.clrErr) timeoutErr <= 1'b0;
      if (strb.setErr) timeoutErr <= 1'b1;
    end
  end

  p_out_needs_rst_r1 : assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> (pllRstN && bypassRel));
  p_rst_needs_byp_r1 : assert property (@(posedge clk) disable iff (!rstN)
    pllRstN |-> bypassRel);

endmodule

// File: rtl/clkmul_seq_ctl.sv
module clkmul_seq_ctl
  import clkmul_seq_pkg::*;
#(
  parameter int BYP_GAP_US = 5,
  parameter int DIS_GAP_US = 1,
  parameter int POLL_MAX   = 100,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enReq,
  input  logic             disReq,
  input  logic             voteStrap,
  input  logic             lockDet,
  input  logic             activeFlag,
  input  logic             tick,
  input  logic [CNT_W-1:0] usCnt,
  input  logic             bypassRel,
  input  logic             pllRstN,
  input  logic             outEn,
  input  logic             timeoutErr,
  output seqStrobe_t       strb,
  output logic             busy,
  output logic             done
);

  seqState_t state, nextState;
  logic allOn, gapEnd, disEnd, pollLast;

  always_comb begin
    allOn    = bypassRel && pllRstN && outEn;
    gapEnd   = tick && (usCnt == CNT_W'(BYP_GAP_US - 1));
    disEnd   = tick && (usCnt == CNT_W'(DIS_GAP_US - 1));
    pollLast = tick && (usCnt == CNT_W'(POLL_MAX - 1));
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (enReq) begin
          strb.clrErr = 1'b1;
          if (voteStrap) begin
            strb.setVote  = 1'b1;
            strb.clrTimer = 1'b1;
            nextState     = S_VOTE_POLL;
          end else if (allOn) begin
            nextState = S_FIN;
          end else begin
            strb.setByp   = 1'b1;
            strb.clrTimer = 1'b1;
            nextState     = S_EN_GAP;
          end
        end else if (disReq) begin
          strb.clrErr = 1'b1;
          if (voteStrap) begin
            strb.clrVote = 1'b1;
            nextState    = S_FIN;
          end else begin
            strb.clrOut   = 1'b1;
            strb.clrTimer = 1'b1;
            nextState     = S_DIS_GAP;
          end
        end
      end
      S_EN_GAP: begin
        if (gapEnd) begin
          strb.setRst   = 1'b1;
          strb.clrTimer = 1'b1;
          nextState     = S_EN_POLL;
        end
      end
      S_EN_POLL: begin
        if (tick && lockDet) begin
          strb.setOut = 1'b1;
          nextState   = S_FIN;
        end else if (pollLast) begin
          strb.setErr = 1'b1;
          nextState   = S_FIN;
        end
      end
      S_VOTE_POLL: begin
        if (tick && activeFlag) begin
          nextState = S_FIN;
        end else if (pollLast) begin
          strb.setErr = 1'b1;
          nextState   = S_FIN;
        end
      end
      S_DIS_GAP: begin
        if (disEnd) begin
          strb.clrRstByp = 1'b1;
          nextState      = S_FIN;
        end
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= nextState;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  p_done_single_r9 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_out_after_lock_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> $past(lockDet));
  p_err_ends_seq_r3 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done);
  p_vote_keeps_ctrl_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_VOTE_POLL) |=> $stable({bypassRel, pllRstN, outEn}));

endmodule

// File: rtl/clkmul_sequencer.sv
module clkmul_sequencer
  import clkmul_seq_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int BYP_GAP_US = 5,
  parameter int DIS_GAP_US = 1,
  parameter int POLL_MAX   = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic enReq,
  input  logic disReq,
  input  logic voteStrap,
  input  logic lockDet,
  input  logic activeFlag,
  output logic bypassRel,
  output logic pllRstN,
  output logic outEn,
  output logic voteOut,
  output logic busy,
  output logic done,
  output logic timeoutErr
);

  localparam int MAX_GAP = (BYP_GAP_US > DIS_GAP_US) ? BYP_GAP_US : DIS_GAP_US;
  localparam int MAX_CNT = (MAX_GAP > POLL_MAX) ? MAX_GAP : POLL_MAX;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  seqStrobe_t       strb;
  logic             tick;
  logic [CNT_W-1:0] usCnt;

  clkmul_seq_ctl #(
    .BYP_GAP_US(BYP_GAP_US),
    .DIS_GAP_US(DIS_GAP_US),
    .POLL_MAX  (POLL_MAX),
    .CNT_W     (CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enReq     (enReq),
    .disReq    (disReq),
    .voteStrap (voteStrap),
    .lockDet   (lockDet),
    .activeFlag(activeFlag),
    .tick      (tick),
    .usCnt     (usCnt),
    .bypassRel (bypassRel),
    .pllRstN   (pllRstN),
    .outEn     (outEn),
    .timeoutErr(timeoutErr),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  clkmul_seq_dp #(
    .TICK_DIV(TICK_DIV),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .tick      (tick),
    .usCnt     (usCnt),
    .bypassRel (bypassRel),
    .pllRstN   (pllRstN),
    .outEn     (outEn),
    .voteOut   (voteOut),
    .timeoutErr(timeoutErr)
  );

endmodule

// File: tb/clkmul_sequencer_bench.sv
module clkmul_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T    = 4;
  localparam int GAP  = 5;
  localparam int DGAP = 1;
  localparam int POLL = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enReq = 1'b0, disReq = 1'b0, voteStrap = 1'b0;
  logic lockDet, activeFlag;
  logic bypassRel, pllRstN, outEn, voteOut, busy, done, timeoutErr;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  int lockDelay = 0;
  int actDelay = 0;
  int lockCnt = 0;
  int actCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Multiplier model: lock rises lockDelay cycles after reset release.
  always @(posedge clk) begin
    if (!pllRstN) lockCnt <= 0;
    else if (lockCnt < 100000) lockCnt <= lockCnt + 1;
    if (!voteOut) actCnt <= 0;
    else if (actCnt < 100000) actCnt <= actCnt + 1;
  end
  assign lockDet    = pllRstN && (lockCnt >= lockDelay);
  assign activeFlag = voteOut && (actCnt >= actDelay);

  clkmul_sequencer #(
    .TICK_DIV(T), .BYP_GAP_US(GAP), .DIS_GAP_US(DGAP), .POLL_MAX(POLL)
  ) u_clkmul_sequencer (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .voteStrap(voteStrap), .lockDet(lockDet), .activeFlag(activeFlag),
    .bypassRel(bypassRel), .pllRstN(pllRstN), .outEn(outEn),
    .voteOut(voteOut), .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycles from the start of polling to the successful sample, or -1 on timeout.
  function automatic int expPoll(input int d);
    int k;
    k = (d + T) / T;
    if (k > POLL) return -1;
    return k * T;
  endfunction

  task automatic runEnable(input int d, input bit injectDis, input bit both);
    int acc, bypC, rstC, outC, doneC, e;
    lockDelay = d;
    voteStrap = 1'b0;
    @(negedge clk);
    enReq = 1'b1;
    disReq = both;
    acc = cyc + 1;
    bypC = -1; rstC = -1; outC = -1; doneC = -1;
    for (int i = 0; i < T * (GAP + POLL) + 40 && doneC < 0; i++) begin
      @(negedge clk);
      enReq = 1'b0;
      disReq = (injectDis && i == 2);
      if (injectDis && i == 2) chk(busy == 1'b1, "R8 busy during gap", busy, 1);
      if (bypassRel && bypC < 0) bypC = cyc;
      if (pllRstN && rstC < 0) rstC = cyc;
      if (outEn && outC < 0) outC = cyc;
      if (done) doneC = cyc;
    end
    disReq = 1'b0;
    chk(bypC == acc, "R1 bypass on accept", bypC, acc);
    chk(rstC - bypC == GAP * T, "R1 reset gap", rstC - bypC, GAP * T);
    e = expPoll(d);
    if (e > 0) begin
      chk(outC - rstC == e, "R2 lock to output", outC - rstC, e);
      chk(doneC == outC, "R2 done with output", doneC, outC);
      chk(timeoutErr == 1'b0, "R2 no error", timeoutErr, 0);
    end else begin
      chk(doneC - rstC == POLL * T, "R3 timeout time", doneC - rstC, POLL * T);
      chk(timeoutErr == 1'b1, "R3 error flag", timeoutErr, 1);
      chk(outEn == 1'b0 && pllRstN && bypassRel, "R3 lines after timeout",
          {outEn, pllRstN, bypassRel}, 3);
    end
    if (injectDis) chk(bypassRel == 1'b1, "R8 disable ignored", bypassRel, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic runDisable();
    int acc, outLo, rbLo, doneC;
    voteStrap = 1'b0;
    @(negedge clk);
    disReq = 1'b1;
    acc = cyc + 1;
    outLo = -1; rbLo = -1; doneC = -1;
    for (int i = 0; i < T * DGAP + 20 && doneC < 0; i++) begin
      @(negedge clk);
      disReq = 1'b0;
      if (!outEn && outLo < 0) outLo = cyc;
      if (!pllRstN && !bypassRel && rbLo < 0) rbLo = cyc;
      if (pllRstN != bypassRel) chk(1'b0, "R5 reset and bypass together", pllRstN, bypassRel);
      if (done) doneC = cyc;
    end
    chk(outLo == acc, "R5 output off on accept", outLo, acc);
    chk(rbLo - outLo == DGAP * T, "R5 disable gap", rbLo - outLo, DGAP * T);
    chk(doneC == rbLo, "R5 done with reset", doneC, rbLo);
    chk(timeoutErr == 1'b0, "R3 error cleared by request", timeoutErr, 0);
    @(negedge clk);
  endtask

  task automatic runVoteEnable(input int a);
    int acc, vC, doneC, e;
    bit touched;
    actDelay = a;
    voteStrap = 1'b1;
    @(negedge clk);
    enReq = 1'b1;
    acc = cyc + 1;
    vC = -1; doneC = -1; touched = 1'b0;
    for (int i = 0; i < T * POLL + 20 && doneC < 0; i++) begin
      @(negedge clk);
      enReq = 1'b0;
      if (voteOut && vC < 0) vC = cyc;
      if (bypassRel || pllRstN || outEn) touched = 1'b1;
      if (done) doneC = cyc;
    end
    chk(vC == acc, "R6 vote on accept", vC, acc);
    chk(touched == 1'b0, "R6 lines untouched", touched, 0);
    e = expPoll(a);
    if (e > 0) begin
      chk(doneC - vC == e, "R6 active seen", doneC - vC, e);
      chk(timeoutErr == 1'b0, "R6 no error", timeoutErr, 0);
    end else begin
      chk(doneC - vC == POLL * T, "R6 vote timeout", doneC - vC, POLL * T);
      chk(timeoutErr == 1'b1, "R6 vote error", timeoutErr, 1);
    end
    @(negedge clk);
  endtask

  task automatic runVoteDisable();
    @(negedge clk);
    disReq = 1'b1;
    @(negedge clk);
    disReq = 1'b0;
    chk(voteOut == 1'b0, "R7 vote withdrawn", voteOut, 0);
    chk(done == 1'b1, "R7 done", done, 1);
    chk({bypassRel, pllRstN, outEn} == 3'b000, "R7 lines untouched",
        {bypassRel, pllRstN, outEn}, 0);
    @(negedge clk);
    voteStrap = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int d;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({bypassRel, pllRstN, outEn, voteOut, busy, done, timeoutErr} == 7'b0,
        "R9 reset state", {bypassRel, pllRstN, outEn, voteOut, busy, done, timeoutErr}, 0);

    // Directed corners: lock on first sample, last sample, never.
    runEnable(0, 1'b0, 1'b0);
    // R4: already on.
    @(negedge clk);
    enReq = 1'b1;
    @(negedge clk);
    enReq = 1'b0;
    chk(done == 1'b1, "R4 immediate done", done, 1);
    chk({bypassRel, pllRstN, outEn} == 3'b111, "R4 lines unchanged",
        {bypassRel, pllRstN, outEn}, 7);
    @(negedge clk);
    chk({bypassRel, pllRstN, outEn} == 3'b111, "R4 lines still unchanged",
        {bypassRel, pllRstN, outEn}, 7);
    runDisable();
    runEnable(POLL * T - 1, 1'b0, 1'b0);
    runDisable();
    runEnable(POLL * T, 1'b0, 1'b0);
    runDisable();
    // R8: disable during enable ignored; simultaneous requests favour enable.
    runEnable(9, 1'b1, 1'b0);
    runDisable();
    runEnable(3, 1'b0, 1'b1);
    runDisable();
    // Vote mode.
    runVoteEnable(5);
    runVoteDisable();
    runVoteEnable(POLL * T + 3);
    runVoteDisable();

    for (int n = 0; n < 24; n++) begin
      d = $urandom_range(0, T * POLL + 8);
      if (n % 5 == 4) begin
        runVoteEnable(d);
        runVoteDisable();
      end else begin
        runEnable(d, (n % 3) == 1, 1'b0);
        runDisable();
      end
    end
    summary();
  end

endmodule